// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches up to 32 asynchronous interrupt pins and turns them into per-line interrupt requests for one CPU. Each pin is brought into the clock domain through a two-stage synchronizer. A per-line 4-bit sense code then selects what counts as an event: a low level, a high level, a rising edge, a falling edge, or either edge. Events are caught in a sticky detect-status vector. Software clears that vector by writing ones to it.

A per-line enable mask gates the latched status onto the line's own interrupt output. The mask has two write addresses: one sets bits and one clears them, so software never needs a read-modify-write. A raw level monitor returns the synchronized pin levels. A request-status view returns the gated status.

The register bus is a plain single-cycle write strobe with a combinational read. The map is: 0x000 request status (read only); 0x004 enable read and write-1-to-disable; 0x008 enable read and write-1-to-enable; 0x100 detect status, write-1-to-clear; 0x104 level monitor (read only); 0x180 + 4*n the sense code of line n in bits [3:0].

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the enable mask, detect status, request status and every sense code read as zero, and every interrupt output is low.
- R2: The register at 0x104 returns the pin levels after a two-flop synchronizer. A pin change driven before clock edge k shows up in the read after edge k+1, and not after edge k alone.
- R3: Writing the register at 0x180 + 4*n stores bits [3:0] of the write data as the sense code of line n. Reading it back returns that code in bits [3:0] and zeros above.
- R4: Sense code 0x2 latches a detection while the synchronized input is high. Sense code 0x1 latches a detection while it is low.
- R5: Sense code 0x8 latches on a low-to-high change only. Code 0x4 latches on a high-to-low change only. Code 0xC latches on either change.
- R6: Sense code 0x0, or any code other than 0x1, 0x2, 0x4, 0x8 and 0xC, never latches a detection.
- R7: Writing 1 to bit n at 0x100 clears line n's detection, and 0 bits have no effect. A clear takes priority over a detection in the same cycle. A line whose level is still active therefore reads 0 right after the clear and latches again one cycle later.
- R8: Writing 1 to bit n at 0x008 enables line n. Writing 1 to bit n at 0x004 disables it. 0 bits leave the mask unchanged, and both addresses read back the mask.
- R9: The register at 0x000 reads detect status AND enable mask. Interrupt output n is high exactly when line n is both latched and enabled.
- R10: A latched detection stays set after its input goes inactive, and also after the line is disabled, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | 32 | Asynchronous interrupt pins |
| irq_out | output | 32 | Per-line interrupt request to the CPU |

## Verification
Some rules are checked by assertions on every cycle:
- the enable set and clear writes take effect on the next edge;
- a status clear wins over any detection in the same cycle;
- latched status never drops without a clear write;
- the outputs are quiet right after reset.

Only the bench scenarios can show the rest:
- the exact meaning of each sense code over input transitions;
- the two-cycle monitor latency;
- the one-cycle gap when a level line latches again after a clear;
- how the mask and the status combine on individual outputs.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CODE_W = 4;

    localparam logic [ADDR_W-1:0] OFS_REQ    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_DET    = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_MON    = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 12'h180;

    localparam logic [CODE_W-1:0] SNS_LOW  = 4'h1;
    localparam logic [CODE_W-1:0] SNS_HIGH = 4'h2;
    localparam logic [CODE_W-1:0] SNS_FALL = 4'h4;
    localparam logic [CODE_W-1:0] SNS_RISE = 4'h8;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/eic_sense.sv
module eic_sense
    import eic_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              cur,
    input  logic              prev,
    output logic              hit
);
    logic edge_mode;

    always_comb begin
        edge_mode = (code[1:0] == 2'b00);
        hit = ((code == SNS_LOW)  && !cur)
            | ((code == SNS_HIGH) &&  cur)
            | (edge_mode && code[2] &&  prev && !cur)
            | (edge_mode && code[3] && !prev &&  cur);
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       irq_out
);
    localparam int unsigned IDX_W = 5;

    typedef struct packed {
        logic [NUM_LINES-1:0]             en;
        logic [NUM_LINES-1:0]             st;
        logic [NUM_LINES-1:0]             prev;
        logic [NUM_LINES-1:0][CODE_W-1:0] cfg;
    } state_t;

    state_t               cur_q;
    state_t               nxt_d;
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] hit_vec;
    logic                 cfg_sel;
    logic [IDX_W-1:0]     cfg_idx;
    logic [NUM_LINES-1:0] wmask;
    logic [NUM_LINES-1:0] status_vec;
    logic [NUM_LINES-1:0] enable_vec;

    eic_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in[NUM_LINES-1:0]),
        .sync_out (sync_lvl)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        eic_sense u_sense (
            .code (cur_q.cfg[g]),
            .cur  (sync_lvl[g]),
            .prev (cur_q.prev[g]),
            .hit  (hit_vec[g])
        );
    end

    assign cfg_sel = (reg_addr[11:7] == OFS_CFG[11:7]) && (reg_addr[1:0] == 2'b00);
    assign cfg_idx = reg_addr[6:2];
    assign wmask   = reg_wdata[NUM_LINES-1:0];

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = sync_lvl;
        if (reg_wr_en && reg_addr == OFS_DET) begin
            nxt_d.st = (cur_q.st | hit_vec) & ~wmask;
        end else begin
            nxt_d.st = cur_q.st | hit_vec;
        end
        if (reg_wr_en && reg_addr == OFS_EN_CLR) begin
            nxt_d.en = cur_q.en & ~wmask;
        end
        if (reg_wr_en && reg_addr == OFS_EN_SET) begin
            nxt_d.en = cur_q.en | wmask;
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (reg_wr_en && cfg_sel && cfg_idx == IDX_W'(i)) begin
                nxt_d.cfg[i] = reg_wdata[CODE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_REQ:                reg_rdata[NUM_LINES-1:0] = cur_q.st & cur_q.en;
            OFS_EN_CLR, OFS_EN_SET: reg_rdata[NUM_LINES-1:0] = cur_q.en;
            OFS_DET:                reg_rdata[NUM_LINES-1:0] = cur_q.st;
            OFS_MON:                reg_rdata[NUM_LINES-1:0] = sync_lvl;
            default: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (cfg_sel && cfg_idx == IDX_W'(i)) begin
                        reg_rdata[CODE_W-1:0] = cur_q.cfg[i];
                    end
                end
            end
        endcase
    end

    assign status_vec = cur_q.st;
    assign enable_vec = cur_q.en;

    always_comb begin
        irq_out = '0;
        irq_out[NUM_LINES-1:0] = cur_q.st & cur_q.en;
    end
endmodule

// File: rtl/eic_chk.sv
module eic_chk
    import eic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_en,
    input logic [11:0]          reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          irq_out,
    input logic [NUM_LINES-1:0] status_vec,
    input logic [NUM_LINES-1:0] enable_vec
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0));

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_DET)
        |=> ((status_vec & $past(reg_wdata[NUM_LINES-1:0])) == '0));

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == OFS_DET)
        |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    // R8
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_EN_SET)
        |=> ((enable_vec & $past(reg_wdata[NUM_LINES-1:0])) == $past(reg_wdata[NUM_LINES-1:0])));

    // R8
    enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_EN_CLR)
        |=> ((enable_vec & $past(reg_wdata[NUM_LINES-1:0])) == '0));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_EN_CLR)
        |=> ((irq_out[NUM_LINES-1:0] & $past(reg_wdata[NUM_LINES-1:0])) == '0));
endmodule

bind ext_irq_ctrl eic_chk #(.NUM_LINES(NUM_LINES)) u_eic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_out    (irq_out),
    .status_vec (status_vec),
    .enable_vec (enable_vec)
);

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out)
    );

    // entry: {sense code, level before, level after, expected latch}
    localparam logic [6:0] VEC [14] = '{
        {4'h2, 1'b0, 1'b1, 1'b1},  // R4 high level present
        {4'h2, 1'b0, 1'b0, 1'b0},  // R4 high level absent
        {4'h1, 1'b1, 1'b0, 1'b1},  // R4 low level present
        {4'h1, 1'b1, 1'b1, 1'b0},  // R4 low level absent
        {4'h8, 1'b0, 1'b1, 1'b1},  // R5 rise on rise
        {4'h8, 1'b1, 1'b0, 1'b0},  // R5 rise ignores fall
        {4'h4, 1'b1, 1'b0, 1'b1},  // R5 fall on fall
        {4'h4, 1'b0, 1'b1, 1'b0},  // R5 fall ignores rise
        {4'hC, 1'b0, 1'b1, 1'b1},  // R5 both on rise
        {4'hC, 1'b1, 1'b0, 1'b1},  // R5 both on fall
        {4'hC, 1'b1, 1'b1, 1'b0},  // R5 both, no change
        {4'h0, 1'b0, 1'b1, 1'b0},  // R6 off, rise
        {4'h0, 1'b1, 1'b0, 1'b0},  // R6 off, fall
        {4'h3, 1'b0, 1'b1, 1'b0}   // R6 unlisted code
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        do_rd(12'h000, rd); check("R1 request", rd, 32'h0);
        do_rd(12'h004, rd); check("R1 enable", rd, 32'h0);
        do_rd(12'h100, rd); check("R1 status", rd, 32'h0);
        do_rd(12'h180, rd); check("R1 cfg0", rd, 32'h0);
        do_rd(12'h1FC, rd); check("R1 cfg31", rd, 32'h0);
        check("R1 irq_out", irq_out, 32'h0);

        // R3 config store and readback
        do_wr(12'h1F8, 32'hFFFF_FFFA);
        do_rd(12'h1F8, rd); check("R3 cfg30 readback", rd, 32'h0000_000A);
        do_wr(12'h1F8, 32'h0);

        // R4 R5 R6 table walk, line k per entry
        for (int k = 0; k < 14; k++) begin
            pin_in[k] = VEC[k][2];
            do_wr(12'h180 + 12'(4 * k), {28'h0, VEC[k][6:3]});
            wait_cyc(5);
            do_wr(12'h100, 32'h1 << k);
            wait_cyc(2);
            pin_in[k] = VEC[k][1];
            wait_cyc(5);
            do_rd(12'h100, rd);
            check($sformatf("R4/R5/R6 entry %0d", k), {31'h0, rd[k]}, {31'h0, VEC[k][0]});
        end

        // R10 line 0 (high level) input removed, status stays
        pin_in[0] = 1'b0;
        wait_cyc(5);
        do_rd(12'h100, rd);
        check("R10 sticky after input drops", {31'h0, rd[0]}, 32'h1);

        // R2 monitor latency on line 20
        pin_in[20] = 1'b1;
        wait_cyc(1);
        do_rd(12'h104, rd); check("R2 monitor after one edge", {31'h0, rd[20]}, 32'h0);
        wait_cyc(1);
        do_rd(12'h104, rd); check("R2 monitor after two edges", {31'h0, rd[20]}, 32'h1);

        // R7 clear with level still active: zero, then latched again
        pin_in[21] = 1'b1;
        do_wr(12'h180 + 12'(4 * 21), 32'h2);
        wait_cyc(5);
        do_wr(12'h100, 32'h0);
        do_rd(12'h100, rd); check("R7 zero bits no effect", {31'h0, rd[21]}, 32'h1);
        do_wr(12'h100, 32'h1 << 21);
        do_rd(12'h100, rd); check("R7 cleared cycle", {31'h0, rd[21]}, 32'h0);
        wait_cyc(1);
        do_rd(12'h100, rd); check("R7 relatch next cycle", {31'h0, rd[21]}, 32'h1);

        // R8 enable set / clear
        do_wr(12'h008, 32'h0040_0005);
        do_rd(12'h004, rd); check("R8 enable after set", rd, 32'h0040_0005);
        do_wr(12'h008, 32'h0);
        do_rd(12'h008, rd); check("R8 zero set no effect", rd, 32'h0040_0005);
        do_wr(12'h004, 32'h1);
        do_rd(12'h004, rd); check("R8 enable after clear", rd, 32'h0040_0004);

        // R9 gating on outputs and request view
        check("R9 line0 latched but disabled", {31'h0, irq_out[0]}, 32'h0);
        check("R9 line2 latched and enabled", {31'h0, irq_out[2]}, 32'h1);
        do_wr(12'h180 + 12'(4 * 22), 32'h8);
        wait_cyc(2);
        check("R9 line22 idle", {31'h0, irq_out[22]}, 32'h0);
        pin_in[22] = 1'b1;
        wait_cyc(4);
        check("R9 line22 raised", {31'h0, irq_out[22]}, 32'h1);
        do_rd(12'h000, rd); check("R9 request view", rd & 32'h0040_0005, 32'h0040_0004);

        // R10 disable does not drop status
        do_wr(12'h004, 32'h1 << 22);
        check("R9 line22 masked", {31'h0, irq_out[22]}, 32'h0);
        do_rd(12'h100, rd); check("R10 status kept when masked", {31'h0, rd[22]}, 32'h1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule